// File: doc/BRIEF.md
# Lockable Watchdog with Bark and Bite

This block is a 32-bit up-counting watchdog that runs from an always-on clock. It advances by one on each cycle where the `tick` strobe is high, but only while it is enabled. Software keeps it from firing by writing zero to the count register, which is called petting.

The block compares the count against two thresholds. When the count reaches the first one, the bark threshold, the block raises three outputs: a level interrupt, a mirrored non-maskable interrupt and a sticky wake request for the power controller. When the count reaches the second one, the bite threshold, the block raises a reset request. The reset request stays high until the block itself is reset.

Software can lock the configuration by clearing a write-enable bit. After that, no write can change the control word, the thresholds or the count until the next reset. Counting halts while the escalation input is high. If the pause-in-sleep mode is selected, counting also halts while a synchronised copy of the sleep input is high.

Registers are written through a plain one-cycle write strobe with a 3-bit select. The register map is:

| Select | Register | Write effect |
|---|---|---|
| 0 | control | bit0 = enable, bit1 = pause-in-sleep |
| 1 | bark threshold | full word |
| 2 | bite threshold | full word |
| 3 | count | full word |
| 4 | write-enable | data bit0 = 0 clears it |
| 5 | interrupt clear | data bit0 = 1 clears the bark status |
| 6 | wake cause | data bit0 = 0 clears the wake request |

Top module: `wdog_guard`

## Requirements
- R1: After reset, the block is in the following state:
  - `count` is 0.
  - `bark_irq`, `bark_nmi`, `wake_req`, `bite_req` and `locked` are all 0.
  - Both thresholds are all-ones.
  - The control word is 0.
- R2: The count advances by exactly one at each clock edge where `tick` is 1, the control enable (select 0, bit0) is 1, and counting is not halted. With `tick` at 0, or with enable at 0, the count holds.
- R3: A write to select 3 loads the written value into the count one edge later. Writing 0 this way is how software pets the watchdog.
- R4: When enable is 1 and the count is greater than or equal to the bark threshold (select 1), the bark status sets at the next edge. The bark status drives `bark_irq` and `bark_nmi`. At the same edge, `wake_req` sets.
- R5: Writing data bit0 = 1 to select 5 clears the bark status. Writing bit0 = 0 has no effect. If the bark condition still holds at that edge, the status stays set.
- R6: Writing data bit0 = 0 to select 6 clears `wake_req`. Writing bit0 = 1 to select 6 has no effect, and clearing the interrupt (select 5) does not clear `wake_req`.
- R7: When enable is 1 and the count is greater than or equal to the bite threshold (select 2), `bite_req` sets at the next edge. It stays set until reset, and it is independent of the bark status.
- R8: Writing data bit0 = 0 to select 4 sets `locked`. From then until reset:
  - Writes to selects 0 to 3 are ignored.
  - Writing 1 to select 4 does not unlock the block.
- R9: With pause-in-sleep (select 0, bit1) set, the count holds while the 2-flop synchronised `sleep_in` is high. A change on `sleep_in` first affects counting at the third clock edge after it. With pause-in-sleep clear, `sleep_in` has no effect.
- R10: While `escalate` is 1, the count holds even with `tick` and enable at 1.
- R11: While enable is 0, neither `bite_req` nor the bark status is raised, even when the count is beyond both thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count strobe, one pulse per timer tick |
| sleep_in | input | 1 | Asynchronous sleep indication |
| escalate | input | 1 | Halts counting while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| count | output | 32 | Current count value |
| bark_irq | output | 1 | Level bark interrupt |
| bark_nmi | output | 1 | Non-maskable copy of the bark interrupt |
| wake_req | output | 1 | Sticky wake request |
| bite_req | output | 1 | Reset request, held until reset |
| locked | output | 1 | Configuration is locked |

## Verification
The hardest situation to reach from the ports is the exact edge at which sleep starts and stops halting the count, because the synchroniser delays it by two edges. The bench raises and drops `sleep_in` while `tick` is held high and checks the count after a known number of cycles. It expects two more increments after `sleep_in` rises, and two held edges after `sleep_in` falls.

The lock is reached by clearing the write-enable bit and then attempting to write the count, the control word and the bark threshold. The bench shows that none of these writes took effect: the count keeps advancing from its old value, and no interrupt fires.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_BARK   = 3'd1,
    SEL_BITE   = 3'd2,
    SEL_COUNT  = 3'd3,
    SEL_WREN   = 3'd4,
    SEL_IRQCLR = 3'd5,
    SEL_WAKE   = 3'd6
  } reg_sel_e;

  typedef struct packed {
    logic pause;
    logic enable;
  } ctrl_t;
endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wdg_cfg.sv
module wdg_cfg
  import wdg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] bark_th,
  output logic [CNT_W-1:0] bite_th,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             irq_clr,
  output logic             wake_clr,
  output logic             locked
);
  logic     wren;
  reg_sel_e sel;
  logic     open_wr;

  assign sel     = reg_sel_e'(wr_addr);
  assign open_wr = wr_en && wren;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wren    <= 1'b1;
      ctrl    <= '0;
      bark_th <= '1;
      bite_th <= '1;
    end else begin
      if (wr_en && sel == SEL_WREN && !wr_data[0]) wren <= 1'b0;
      if (open_wr && sel == SEL_CTRL) ctrl <= ctrl_t'(wr_data[1:0]);
      if (open_wr && sel == SEL_BARK) bark_th <= wr_data;
      if (open_wr && sel == SEL_BITE) bite_th <= wr_data;
    end
  end

  assign load     = open_wr && sel == SEL_COUNT;
  assign load_val = wr_data;
  assign irq_clr  = wr_en && sel == SEL_IRQCLR && wr_data[0];
  assign wake_clr = wr_en && sel == SEL_WAKE && !wr_data[0];
  assign locked   = !wren;

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  assert_locked_cfg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(ctrl) && $stable(bark_th) && $stable(bite_th)));
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic             pause_en,
  input  logic             sleep_s,
  input  logic             escalate,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);
  logic halted;
  logic run;

  assign halted = escalate || (pause_en && sleep_s);
  assign run    = tick && enable && !halted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (run)  count <= count + CNT_W'(1);
  end

  assert_esc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (escalate && !load) |=> $stable(count));
  assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_en && sleep_s && !load) |=> $stable(count));
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((!tick || !enable) && !load) |=> $stable(count));
endmodule

// File: rtl/wdg_alarm.sv
module wdg_alarm #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] bark_th,
  input  logic [CNT_W-1:0] bite_th,
  input  logic             irq_clr,
  input  logic             wake_clr,
  output logic             bark_st,
  output logic             wake_req,
  output logic             bite_req
);
  logic bark_hit;
  logic bite_hit;

  assign bark_hit = enable && (count >= bark_th);
  assign bite_hit = enable && (count >= bite_th);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bark_st  <= 1'b0;
      wake_req <= 1'b0;
      bite_req <= 1'b0;
    end else begin
      bark_st  <= bark_hit || (bark_st && !irq_clr);
      wake_req <= bark_hit || (wake_req && !wake_clr);
      bite_req <= bite_hit || bite_req;
    end
  end

  assert_bark_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bark_hit |=> (bark_st && wake_req));
  assert_bite_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bite_req |=> bite_req);
  assert_wake_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !wake_clr) |=> wake_req);
  assert_quiet_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !bite_req) |=> !bite_req);
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdg_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sleep_in,
  input  logic             escalate,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic             bark_irq,
  output logic             bark_nmi,
  output logic             wake_req,
  output logic             bite_req,
  output logic             locked
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] bark_th;
  logic [CNT_W-1:0] bite_th;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             irq_clr;
  logic             wake_clr;
  logic             sleep_s;
  logic             bark_st;

  wdg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sleep_in), .q(sleep_s)
  );

  wdg_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl), .bark_th(bark_th), .bite_th(bite_th),
    .load(load), .load_val(load_val), .irq_clr(irq_clr),
    .wake_clr(wake_clr), .locked(locked)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(ctrl.enable),
    .pause_en(ctrl.pause), .sleep_s(sleep_s), .escalate(escalate),
    .load(load), .load_val(load_val), .count(count)
  );

  wdg_alarm #(.CNT_W(CNT_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .enable(ctrl.enable), .count(count),
    .bark_th(bark_th), .bite_th(bite_th), .irq_clr(irq_clr),
    .wake_clr(wake_clr), .bark_st(bark_st), .wake_req(wake_req),
    .bite_req(bite_req)
  );

  assign bark_irq = bark_st;
  assign bark_nmi = bark_st;
endmodule

// File: tb/wdog_guard_bench.sv
`timescale 1ns/1ps
module wdog_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        sleep_in = 1'b0;
  logic        escalate = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] count;
  logic        bark_irq, bark_nmi, wake_req, bite_req, locked;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    int          sel;
    logic [31:0] val;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  wdog_guard u_wdog_guard (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sleep_in(sleep_in),
    .escalate(escalate), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .bark_irq(bark_irq),
    .bark_nmi(bark_nmi), .wake_req(wake_req), .bite_req(bite_req),
    .locked(locked)
  );

  function automatic logic [31:0] observe(int sel);
    case (sel)
      0: return count;
      1: return {31'd0, bark_irq};
      2: return {31'd0, bark_nmi};
      3: return {31'd0, wake_req};
      4: return {31'd0, bite_req};
      default: return {31'd0, locked};
    endcase
  endfunction

  // driver side: queue an expectation for the current negedge
  task automatic expect_out(int sel, logic [31:0] val, string req);
    exp_t e;
    e.sel = sel; e.val = val; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: compares queued expectations just after each negedge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        exp_t e;
        logic [31:0] act;
        e = exp_q.pop_front();
        act = observe(e.sel);
        checks++;
        if (act !== e.val) begin
          fails++;
          $display("FAIL %s: output %0d actual %0h expected %0h", e.req, e.sel, act, e.val);
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(1);
    do_reset();
    // R1 reset state
    expect_out(0, 0, "R1"); expect_out(1, 0, "R1"); expect_out(2, 0, "R1");
    expect_out(3, 0, "R1"); expect_out(4, 0, "R1"); expect_out(5, 0, "R1");

    // R2 counting only with tick
    wr(1, 10); wr(2, 20); wr(0, 1);
    step(3); expect_out(0, 0, "R2");
    tick = 1'b1; step(5); tick = 1'b0;
    expect_out(0, 5, "R2");

    // R3 load, R4 bark
    wr(3, 9); expect_out(0, 9, "R3");
    tick = 1'b1; step(1); tick = 1'b0;
    expect_out(0, 10, "R4"); expect_out(1, 0, "R4");
    step(1);
    expect_out(1, 1, "R4"); expect_out(2, 1, "R4"); expect_out(3, 1, "R4");

    // R5/R6 clearing
    wr(3, 0); expect_out(0, 0, "R3");
    wr(5, 0); expect_out(1, 1, "R5");
    wr(5, 1); expect_out(1, 0, "R5"); expect_out(2, 0, "R5"); expect_out(3, 1, "R6");
    wr(6, 1); expect_out(3, 1, "R6");
    wr(6, 0); expect_out(3, 0, "R6");

    // R11 disabled
    wr(0, 0); wr(3, 50);
    tick = 1'b1; step(3); tick = 1'b0;
    expect_out(0, 50, "R11"); expect_out(1, 0, "R11"); expect_out(4, 0, "R11");

    // R10 escalation
    wr(3, 0); wr(0, 1);
    escalate = 1'b1; tick = 1'b1; step(4);
    expect_out(0, 0, "R10");
    escalate = 1'b0; step(3); tick = 1'b0;
    expect_out(0, 3, "R10");

    // R9 pause in sleep with synchroniser latency
    wr(0, 3);
    sleep_in = 1'b1; tick = 1'b1; step(5);
    expect_out(0, 5, "R9");
    sleep_in = 1'b0; step(4); tick = 1'b0;
    expect_out(0, 7, "R9");
    wr(3, 0); wr(0, 1);
    sleep_in = 1'b1; step(3);
    tick = 1'b1; step(3); tick = 1'b0;
    expect_out(0, 3, "R9");
    sleep_in = 1'b0; step(3);

    // R7 bite independent of bark, sticky
    wr(1, 32'hFFFF_FFFF); wr(2, 5); wr(3, 4);
    tick = 1'b1; step(1); tick = 1'b0;
    expect_out(0, 5, "R7"); expect_out(4, 0, "R7");
    step(1);
    expect_out(4, 1, "R7"); expect_out(1, 0, "R7");
    wr(3, 0); step(2);
    expect_out(4, 1, "R7");

    // R8 lock
    wr(4, 1); expect_out(5, 0, "R8");
    wr(4, 0); expect_out(5, 1, "R8");
    wr(4, 1); expect_out(5, 1, "R8");
    wr(3, 77); expect_out(0, 0, "R8");
    wr(0, 0); wr(1, 0);
    tick = 1'b1; step(2); tick = 1'b0;
    expect_out(0, 2, "R8");
    step(1); expect_out(1, 0, "R8");

    // R1 reset clears bite and lock
    do_reset();
    expect_out(4, 0, "R1"); expect_out(5, 0, "R1"); expect_out(0, 0, "R1");

    step(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule